// File: doc/BRIEF.md
# Speculative Read-Side Availability Synchronizer

This block sits on the read side of a dual-clock FIFO and carries the FIFO's not-empty condition into the reader's clock domain faster than a conventional two-flop synchronizer. Rather than waiting two full read clocks, it samples the asynchronous not-empty condition twice within a single read cycle. The first sample is taken slightly before the middle of the cycle, and the second at the middle. The second sample drives a speculative data-available flag for the second half of the cycle. The consumer may act on that flag at once.

At the rising edge that ends the cycle, the block compares the two samples. If they agree, the speculation stood. If they differ, the mid-cycle sample may have been taken while the sampler was still settling. In that case a one-cycle read-fail pulse is raised, and the consumer discards whatever it took and repeats the read later. In a failed cycle, the pop request from the consumer is blocked, so the FIFO read pointer does not move. A retry therefore returns the same word.

In this model, the two sample points are two registers on the falling edge of the read clock. Each register has its own input path, so that the sampling disagreement a settling sampler can produce can be applied directly. A value that is still unresolved when the cycle ends is outside what the block handles.

Top module: `spec_rd_sync`

## Requirements
- R1: While `rst` is high at a clock edge, both samples, `avail_o`, `fail_o` and `pop_ok_o` are cleared to 0.
- R2: `avail_o` equals the value of `ne_spec_i` captured at the most recent falling edge of `clk`. It holds from that falling edge to the next one.
- R3: If the early sample (`ne_early_i` at the falling edge) differs from the speculative sample (`ne_spec_i` at the same falling edge), `fail_o` is 1 for the clock cycle after the following rising edge. This covers both early 0 / speculative 1 and early 1 / speculative 0.
- R4: If the two samples agree, `fail_o` is 0 for the next cycle. Agreement at 0 means no data; agreement at 1 means a normal transfer.
- R5: A pop request (`pop_i` = 1) in a cycle whose samples disagree is suppressed: `pop_ok_o` stays 0, so the read pointer does not advance.
- R6: `pop_ok_o` is 1 exactly when `pop_i` is 1 and both samples of the current cycle are 1. A pop while no data is available is not accepted.
- R7: A read that is failed and then repeated in a later cycle with agreeing samples at 1 is accepted once. The repeated read delivers the same data word the failed read saw.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| ne_early_i | input | 1 | Not-empty path to the early sampler |
| ne_spec_i | input | 1 | Not-empty path to the mid-cycle sampler |
| pop_i | input | 1 | Read-done request from the consumer |
| avail_o | output | 1 | Speculative data available, valid in the second half of the cycle |
| pop_ok_o | output | 1 | Accepted pop; advances the FIFO read pointer at the rising edge |
| fail_o | output | 1 | One-cycle read-fail pulse; the consumer repeats the read |

## Verification
The assertions assume that both not-empty paths and `pop_i` change only in the first half of the read cycle, so that each falling edge sees settled values. They also assume that any metastable value has resolved before the rising edge. The stimulus changes all three inputs two nanoseconds after each rising edge. The first check is made after the falling edge and the second after the next rising edge, which keeps every sample point clear of input changes. The sweep applies every combination of the two sample values and the pop request, in more than one order. It then runs a failed read followed by its retry against a small FIFO model held in the bench.

// File: rtl/spec_rd_sync.sv
module spec_rd_sync (
  input  logic clk,
  input  logic rst,
  input  logic ne_early_i,
  input  logic ne_spec_i,
  input  logic pop_i,
  output logic avail_o,
  output logic pop_ok_o,
  output logic fail_o
);

  logic early_q;
  logic spec_q;
  logic fail_q;

  always_ff @(negedge clk) begin
    if (rst) begin
      early_q <= 1'b0;
      spec_q  <= 1'b0;
    end else begin
      early_q <= ne_early_i;
      spec_q  <= ne_spec_i;
    end
  end

  wire mismatch = early_q ^ spec_q;

  always_ff @(posedge clk) begin
    if (rst) fail_q <= 1'b0;
    else     fail_q <= mismatch;
  end

  assign avail_o  = spec_q;
  assign pop_ok_o = pop_i & spec_q & early_q & ~rst;
  assign fail_o   = fail_q;

endmodule

module spec_rd_sync_chk (
  input logic clk,
  input logic rst,
  input logic early_q,
  input logic spec_q,
  input logic pop_i,
  input logic avail_o,
  input logic pop_ok_o,
  input logic fail_o
);

  p_fail_on_mismatch_r3: assert property (@(posedge clk) disable iff (rst)
    (early_q != spec_q) |=> fail_o);

  p_quiet_on_agree_r4: assert property (@(posedge clk) disable iff (rst)
    (early_q == spec_q) |=> !fail_o);

  p_pop_blocked_r5: assert property (@(posedge clk) disable iff (rst)
    pop_ok_o |=> !fail_o);

  p_pop_needs_data_r6: assert property (@(posedge clk) disable iff (rst)
    pop_ok_o |-> (avail_o && pop_i));

  p_fail_single_r3: assert property (@(posedge clk) disable iff (rst)
    (fail_o && (early_q == spec_q)) |=> !fail_o);

endmodule

bind spec_rd_sync spec_rd_sync_chk chk_i (
  .clk(clk), .rst(rst), .early_q(early_q), .spec_q(spec_q),
  .pop_i(pop_i), .avail_o(avail_o), .pop_ok_o(pop_ok_o), .fail_o(fail_o)
);

// File: tb/spec_rd_sync_tb_top.sv
`timescale 1ns/1ps
module spec_rd_sync_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ne_early_i = 1'b0;
  logic ne_spec_i = 1'b0;
  logic pop_i = 1'b0;
  logic avail_o, pop_ok_o, fail_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] mem [0:3];
  int rd_ptr = 0;

  always #10 clk = ~clk;

  spec_rd_sync dut_i (
    .clk(clk), .rst(rst), .ne_early_i(ne_early_i), .ne_spec_i(ne_spec_i),
    .pop_i(pop_i), .avail_o(avail_o), .pop_ok_o(pop_ok_o), .fail_o(fail_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Entered at posedge + 2 ns; returns at the next posedge + 2 ns.
  task automatic cyc(input logic e, input logic s, input logic p,
                     output logic accepted);
    ne_early_i = e;
    ne_spec_i  = s;
    pop_i      = p;
    @(negedge clk); #5;
    chk("R2 avail", avail_o, s);
    if (e != s) chk("R5 pop blocked", pop_ok_o, 1'b0);
    else        chk("R6 pop accept", pop_ok_o, p & e & s);
    accepted = pop_ok_o;
    @(posedge clk); #2;
    if (e != s) chk("R3 fail pulse", fail_o, 1'b1);
    else        chk("R4 no fail", fail_o, 1'b0);
  endtask

  initial begin
    logic acc;
    logic [7:0] first_word;
    logic [7:0] second_word;
    for (int i = 0; i < 4; i++) mem[i] = 8'hA0 + 8'(i * 7);

    ne_early_i = 1'b1; ne_spec_i = 1'b1; pop_i = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    chk("R1 reset avail", avail_o, 1'b0);
    chk("R1 reset fail", fail_o, 1'b0);
    chk("R1 reset pop_ok", pop_ok_o, 1'b0);
    @(posedge clk); #2;
    rst = 1'b0;

    for (int pass = 0; pass < 2; pass++) begin
      for (int k = 0; k < 8; k++) begin
        int code = (pass == 0) ? k : 7 - k;
        cyc(code[2], code[1], code[0], acc);
      end
    end

    cyc(1'b0, 1'b1, 1'b0, acc);
    cyc(1'b0, 1'b1, 1'b0, acc);
    cyc(1'b1, 1'b0, 1'b0, acc);
    cyc(1'b1, 1'b1, 1'b0, acc);

    // R7: failed read, then retry returns same word
    rd_ptr = 1;
    first_word = mem[rd_ptr];
    cyc(1'b0, 1'b1, 1'b1, acc);
    if (acc) rd_ptr++;
    chk("R7 failed read no advance", (rd_ptr == 1), 1'b1);
    second_word = mem[rd_ptr];
    cyc(1'b1, 1'b1, 1'b1, acc);
    if (acc) rd_ptr++;
    checks++;
    if (second_word !== first_word) begin
      errors++;
      $display("FAIL R7 retry word: got %0h expected %0h", second_word, first_word);
    end
    chk("R7 retry advanced once", (rd_ptr == 2), 1'b1);

    cyc(1'b0, 1'b1, 1'b0, acc);
    rst = 1'b1;
    ne_early_i = 1'b1; ne_spec_i = 1'b0; pop_i = 1'b1;
    @(negedge clk); #5;
    chk("R1 reset mid-run avail", avail_o, 1'b0);
    chk("R1 reset mid-run pop_ok", pop_ok_o, 1'b0);
    @(posedge clk); #2;
    chk("R1 reset mid-run fail", fail_o, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      #(20 * 200000);
    join_any
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule